// File: doc/BRIEF.md
# Stack and Register-Pair Sequencer

This block holds the working register pairs of a small byte-oriented processor: three general pairs (BC, DE, HL), the processor status word (accumulator in the high byte, flags in the low byte), the stack pointer and the program counter. It carries out the stack-related commands that an instruction decoder hands it, using a byte-wide synchronous memory port. A command is presented with a one-cycle `start` pulse, and the block answers with a one-cycle `done` pulse when its register and memory effects are complete.

The supported commands are a direct load of a register, push and pop of a pair, subroutine call and return (each optionally conditional on one flag), a swap of HL with DE, and a swap of HL with the two bytes on top of the stack. Memory reads return data one cycle after the read strobe, as a block RAM does. Conditional calls and returns whose condition fails finish at once and never touch memory.

Top module: `stk_seq`

## Requirements
- R1: While `rst` is high, and in the cycle after it, every register output is 0 and `mem_rd`, `mem_wr`, `busy` and `done` are low.
- R2: Command 0 (load) writes `operand` into the register chosen by `pair_sel` (0 BC, 1 DE, 2 HL, 3 PSW, 4 SP, 5 PC), makes no memory access and pulses `done` in the first cycle after the start cycle.
- R3: Command 1 (push, `pair_sel` 0 BC, 1 DE, 2 HL, 3 PSW) writes the high byte to SP-1, then the low byte to SP-2, then lowers SP by 2; the PSW high byte is the accumulator. Exactly two write cycles occur and `done` rises in the fourth cycle after start.
- R4: Command 2 (pop) reads SP then SP+1, loads the pair with {byte at SP+1, byte at SP}, raises SP by 2, and pulses `done` in the fifth cycle after start after exactly two reads.
- R5: Command 3 (call) pushes PC+3 in the R3 byte order and then loads PC with `operand`.
- R6: Command 4 (return) pops a 16-bit value in the R4 byte order into PC.
- R7: With `cond_en` high, call and return proceed only if the flag picked by `cond_code[2:1]` (0 Zero at PSW bit 6, 1 Carry at bit 0, 2 Parity at bit 2, 3 Sign at bit 7) equals `cond_code[0]`; otherwise `done` pulses in the first cycle after start with no memory access and no register change. With `cond_en` low the command always proceeds.
- R8: Command 5 swaps HL and DE, with no memory access, and pulses `done` in the first cycle after start.
- R9: Command 6 swaps L with the byte at SP and H with the byte at SP+1, leaves SP unchanged, makes two reads and two writes, and pulses `done` in the sixth cycle after start.
- R10: Stack addresses and SP arithmetic wrap modulo 65536.
- R11: A `start` pulse while `busy` is high is ignored; SP and PC hold their values during a command until its final cycle.
- R12: Command 7 does nothing and pulses `done` in the first cycle after start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle command request |
| cmd | input | 3 | Command code |
| pair_sel | input | 3 | Register or pair selector |
| cond_code | input | 3 | Flag select [2:1] and wanted state [0] |
| cond_en | input | 1 | Make call/return conditional |
| operand | input | 16 | Load value or call target |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid one cycle after a read strobe |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| bc_q | output | 16 | BC pair |
| de_q | output | 16 | DE pair |
| hl_q | output | 16 | HL pair |
| psw_q | output | 16 | Accumulator and flags |
| sp_q | output | 16 | Stack pointer |
| pc_q | output | 16 | Program counter |

## Verification
A wrong step counter or latched command shows within a few cycles as a misplaced or extra strobe, a `done` pulse at the wrong cycle count, or SP moving by the wrong amount. A byte-order error on push is invisible to a push/pop round trip, so the stack bytes themselves are compared after pushes, calls and the stack exchange. A faulty flag selection shows at once as a call or return taken or skipped, seen in PC, SP and the latency of `done`.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [2:0] {
    OP_LOAD = 3'd0,
    OP_PUSH = 3'd1,
    OP_POP  = 3'd2,
    OP_CALL = 3'd3,
    OP_RET  = 3'd4,
    OP_XDE  = 3'd5,
    OP_XSTK = 3'd6,
    OP_NONE = 3'd7
  } op_e;

  typedef enum logic { ST_IDLE, ST_BUSY } st_e;

  localparam logic [2:0] SEL_BC  = 3'd0;
  localparam logic [2:0] SEL_DE  = 3'd1;
  localparam logic [2:0] SEL_HL  = 3'd2;
  localparam logic [2:0] SEL_PSW = 3'd3;
  localparam logic [2:0] SEL_SP  = 3'd4;
  localparam logic [2:0] SEL_PC  = 3'd5;
endpackage

// File: rtl/stk_cond_eval.sv
module stk_cond_eval (
  input  logic       f_zero,
  input  logic       f_carry,
  input  logic       f_par,
  input  logic       f_sign,
  input  logic [2:0] cond_code,
  input  logic       cond_en,
  output logic       take
);
  logic flag;
  always_comb begin
    case (cond_code[2:1])
      2'd0:    flag = f_zero;
      2'd1:    flag = f_carry;
      2'd2:    flag = f_par;
      default: flag = f_sign;
    endcase
    take = !cond_en || (flag == cond_code[0]);
  end
endmodule

// File: rtl/stk_pair_sel.sv
module stk_pair_sel #(
  parameter int PW = 16
) (
  input  logic [PW-1:0] bc,
  input  logic [PW-1:0] de,
  input  logic [PW-1:0] hl,
  input  logic [PW-1:0] psw,
  input  logic [1:0]    sel,
  output logic [PW-1:0] val
);
  always_comb begin
    case (sel)
      2'd0:    val = bc;
      2'd1:    val = de;
      2'd2:    val = hl;
      default: val = psw;
    endcase
  end
endmodule

// File: rtl/stk_mem_port.sv
module stk_mem_port #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_rd,
  input  logic          req_wr,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_rd    <= 1'b0;
      mem_wr    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_rd    <= req_rd;
      mem_wr    <= req_wr;
      mem_addr  <= req_addr;
      mem_wdata <= req_wdata;
    end
  end
endmodule

// File: rtl/stk_seq.sv
module stk_seq
  import stk_pkg::*;
#(
  parameter int DW       = 8,
  parameter int CALL_LEN = 3,
  parameter int ZB       = 6,
  parameter int CB       = 0,
  parameter int PB       = 2,
  parameter int SB       = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [2:0]      cmd,
  input  logic [2:0]      pair_sel,
  input  logic [2:0]      cond_code,
  input  logic            cond_en,
  input  logic [2*DW-1:0] operand,
  output logic            busy,
  output logic            done,
  output logic [2*DW-1:0] mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic [2*DW-1:0] bc_q,
  output logic [2*DW-1:0] de_q,
  output logic [2*DW-1:0] hl_q,
  output logic [2*DW-1:0] psw_q,
  output logic [2*DW-1:0] sp_q,
  output logic [2*DW-1:0] pc_q
);
  localparam int PW = 2 * DW;
  localparam int SW = 3;
  localparam logic [SW-1:0] LAST_WR = SW'(2);
  localparam logic [SW-1:0] LAST_RD = SW'(3);
  localparam logic [SW-1:0] LAST_XS = SW'(4);

  st_e           state;
  op_e           op_q;
  op_e           cmd_op;
  logic [1:0]    sel_q;
  logic [PW-1:0] opnd_q;
  logic [SW-1:0] stp;
  logic [SW-1:0] last;
  logic [DW-1:0] lo_q;
  logic [DW-1:0] hi_q;
  logic          take;
  logic [PW-1:0] pair_val;
  logic [PW-1:0] push_word;
  logic          req_rd;
  logic          req_wr;
  logic [PW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic [PW-1:0] popped;

  assign cmd_op = op_e'(cmd);
  assign busy   = (state == ST_BUSY);
  assign popped = {mem_rdata, lo_q};

  stk_cond_eval cond_i (
    .f_zero   (psw_q[ZB]),
    .f_carry  (psw_q[CB]),
    .f_par    (psw_q[PB]),
    .f_sign   (psw_q[SB]),
    .cond_code(cond_code),
    .cond_en  (cond_en),
    .take     (take)
  );

  stk_pair_sel #(.PW(PW)) psel_i (
    .bc (bc_q),
    .de (de_q),
    .hl (hl_q),
    .psw(psw_q),
    .sel(sel_q),
    .val(pair_val)
  );

  stk_mem_port #(.AW(PW), .DW(DW)) mport_i (
    .clk      (clk),
    .rst      (rst),
    .req_rd   (req_rd),
    .req_wr   (req_wr),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata)
  );

  assign push_word = (op_q == OP_CALL) ? (pc_q + PW'(CALL_LEN)) : pair_val;

  always_comb begin
    case (op_q)
      OP_PUSH, OP_CALL: last = LAST_WR;
      OP_POP,  OP_RET:  last = LAST_RD;
      default:          last = LAST_XS;
    endcase
  end

  // access schedule, one access per step
  always_comb begin
    req_rd    = 1'b0;
    req_wr    = 1'b0;
    req_addr  = sp_q;
    req_wdata = '0;
    if (state == ST_BUSY) begin
      case (op_q)
        OP_PUSH, OP_CALL: begin
          if (stp == SW'(0)) begin
            req_wr    = 1'b1;
            req_addr  = sp_q - PW'(1);
            req_wdata = push_word[PW-1:DW];
          end else if (stp == SW'(1)) begin
            req_wr    = 1'b1;
            req_addr  = sp_q - PW'(2);
            req_wdata = push_word[DW-1:0];
          end
        end
        OP_POP, OP_RET, OP_XSTK: begin
          if (stp == SW'(0)) begin
            req_rd   = 1'b1;
            req_addr = sp_q;
          end else if (stp == SW'(1)) begin
            req_rd   = 1'b1;
            req_addr = sp_q + PW'(1);
          end else if (op_q == OP_XSTK && stp == SW'(2)) begin
            req_wr    = 1'b1;
            req_addr  = sp_q;
            req_wdata = hl_q[DW-1:0];
          end else if (op_q == OP_XSTK && stp == SW'(3)) begin
            req_wr    = 1'b1;
            req_addr  = sp_q + PW'(1);
            req_wdata = hl_q[PW-1:DW];
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      op_q   <= OP_NONE;
      sel_q  <= '0;
      opnd_q <= '0;
      stp    <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      done   <= 1'b0;
      bc_q   <= '0;
      de_q   <= '0;
      hl_q   <= '0;
      psw_q  <= '0;
      sp_q   <= '0;
      pc_q   <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            op_q   <= cmd_op;
            sel_q  <= pair_sel[1:0];
            opnd_q <= operand;
            stp    <= '0;
            case (cmd_op)
              OP_LOAD: begin
                case (pair_sel)
                  SEL_BC:  bc_q  <= operand;
                  SEL_DE:  de_q  <= operand;
                  SEL_HL:  hl_q  <= operand;
                  SEL_PSW: psw_q <= operand;
                  SEL_SP:  sp_q  <= operand;
                  SEL_PC:  pc_q  <= operand;
                  default: ;
                endcase
                done <= 1'b1;
              end
              OP_XDE: begin
                hl_q <= de_q;
                de_q <= hl_q;
                done <= 1'b1;
              end
              OP_PUSH, OP_POP, OP_XSTK: state <= ST_BUSY;
              OP_CALL, OP_RET: begin
                if (take) state <= ST_BUSY;
                else      done  <= 1'b1;
              end
              default: done <= 1'b1;
            endcase
          end
        end
        default: begin
          stp <= stp + SW'(1);
          if (stp == SW'(2)) lo_q <= mem_rdata;
          if (stp == SW'(3)) hi_q <= mem_rdata;
          if (stp == last) begin
            state <= ST_IDLE;
            done  <= 1'b1;
            case (op_q)
              OP_PUSH: sp_q <= sp_q - PW'(2);
              OP_CALL: begin
                sp_q <= sp_q - PW'(2);
                pc_q <= opnd_q;
              end
              OP_POP: begin
                sp_q <= sp_q + PW'(2);
                case (sel_q)
                  2'd0:    bc_q  <= popped;
                  2'd1:    de_q  <= popped;
                  2'd2:    hl_q  <= popped;
                  default: psw_q <= popped;
                endcase
              end
              OP_RET: begin
                sp_q <= sp_q + PW'(2);
                pc_q <= popped;
              end
              default: hl_q <= {hi_q, lo_q};
            endcase
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/stk_seq_chk.sv
module stk_seq_chk #(
  parameter int DW = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            busy,
  input logic            done,
  input logic            mem_rd,
  input logic            mem_wr,
  input logic [2*DW-1:0] sp_q,
  input logic [2*DW-1:0] pc_q
);
  // R1: one cycle after reset everything is quiet and cleared
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!mem_rd && !mem_wr && !done && !busy && sp_q == '0 && pc_q == '0));

  // R12: completion is reported only once the sequencer is idle again
  a_r12_done_when_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R3: read and write strobes never overlap
  a_r3_rd_wr_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  // R7: memory is only touched while a command is in progress
  a_r7_strobe_needs_busy: assert property (@(posedge clk) disable iff (rst)
    (mem_rd || mem_wr) |-> busy);

  // R11: SP holds until the final cycle of a command
  a_r11_sp_held: assert property (@(posedge clk) disable iff (rst)
    busy |=> (done || $stable(sp_q)));

  // R5: PC holds until the final cycle of a command
  a_r5_pc_held: assert property (@(posedge clk) disable iff (rst)
    busy |=> (done || $stable(pc_q)));
endmodule

bind stk_seq stk_seq_chk #(.DW(DW)) chk_i (.*);

// File: tb/stk_seq_tb_top.sv
module stk_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  cmd = '0;
  logic [2:0]  pair_sel = '0;
  logic [2:0]  cond_code = '0;
  logic        cond_en = 1'b0;
  logic [15:0] operand = '0;
  logic        busy, done, mem_rd, mem_wr;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;
  logic [15:0] bc_q, de_q, hl_q, psw_q, sp_q, pc_q;

  logic [7:0]  mem [256];
  int          acc_cnt = 0;
  int          nchk = 0;
  int          nfail = 0;

  always #2 clk = ~clk;

  stk_seq dut_i (.*);

  always @(posedge clk) begin
    if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
    if (mem_rd || mem_wr) acc_cnt <= acc_cnt + 1;
  end

  // vector: cmd sel cc cen operand | reg to check, expected | mem check en, addr, data | req
  function automatic logic [71:0] v(input logic [2:0] c, input logic [2:0] s,
      input logic [2:0] cc, input logic ce, input logic [15:0] op,
      input logic [2:0] rs, input logic [15:0] ex, input logic me,
      input logic [7:0] ma, input logic [7:0] md, input logic [3:0] rq);
    return {c, s, cc, ce, op, rs, ex, me, ma, md, rq, 6'd0};
  endfunction

  localparam logic [71:0] VEC [29] = '{
    v(0,0,0,0,16'h1234, 0,16'h1234, 0,8'h00,8'h00, 2),  // R2 load BC
    v(0,1,0,0,16'h5678, 1,16'h5678, 0,8'h00,8'h00, 2),  // R2 load DE
    v(0,2,0,0,16'h9ABC, 2,16'h9ABC, 0,8'h00,8'h00, 2),  // R2 load HL
    v(0,4,0,0,16'h0080, 4,16'h0080, 0,8'h00,8'h00, 2),  // R2 load SP
    v(0,3,0,0,16'hA5C4, 3,16'hA5C4, 0,8'h00,8'h00, 2),  // R2 load PSW: S=1 Z=1 P=1 C=0
    v(1,0,0,0,16'h0000, 4,16'h007E, 1,8'h7F,8'h12, 3),  // R3 push BC, high byte at SP-1
    v(1,3,0,0,16'h0000, 4,16'h007C, 1,8'h7D,8'hA5, 3),  // R3 push PSW, accumulator high
    v(2,1,0,0,16'h0000, 1,16'hA5C4, 1,8'h7C,8'hC4, 4),  // R4 pop DE
    v(2,2,0,0,16'h0000, 2,16'h1234, 0,8'h00,8'h00, 4),  // R4 pop HL
    v(0,5,0,0,16'h2000, 5,16'h2000, 0,8'h00,8'h00, 2),  // R2 load PC
    v(3,0,0,0,16'h3000, 5,16'h3000, 1,8'h7F,8'h20, 5),  // R5 call, return addr 2003
    v(7,0,0,0,16'h0000, 4,16'h007E, 1,8'h7E,8'h03, 5),  // R5 SP after call
    v(3,0,3,1,16'h5555, 5,16'h3000, 0,8'h00,8'h00, 7),  // R7 call if carry, C=0: skip
    v(3,0,1,1,16'h4000, 5,16'h4000, 1,8'h7C,8'h03, 7),  // R7 call if zero, Z=1: taken
    v(4,0,4,1,16'h0000, 5,16'h4000, 0,8'h00,8'h00, 7),  // R7 return if parity clear, P=1: skip
    v(4,0,7,1,16'h0000, 5,16'h3003, 0,8'h00,8'h00, 6),  // R6 return if sign set: taken
    v(4,0,0,0,16'h0000, 5,16'h2003, 0,8'h00,8'h00, 6),  // R6 return
    v(7,0,0,0,16'h0000, 4,16'h0080, 0,8'h00,8'h00, 12), // R12 nop, SP restored
    v(5,0,0,0,16'h0000, 2,16'hA5C4, 0,8'h00,8'h00, 8),  // R8 swap HL/DE
    v(7,0,0,0,16'h0000, 1,16'h1234, 0,8'h00,8'h00, 8),  // R8 DE after swap
    v(0,2,0,0,16'h55AA, 2,16'h55AA, 0,8'h00,8'h00, 2),  // R2 load HL
    v(1,0,0,0,16'h0000, 4,16'h007E, 0,8'h00,8'h00, 3),  // R3 push BC
    v(6,0,0,0,16'h0000, 2,16'h1234, 1,8'h7E,8'hAA, 9),  // R9 swap HL with stack top
    v(7,0,0,0,16'h0000, 4,16'h007E, 1,8'h7F,8'h55, 9),  // R9 SP unchanged
    v(2,0,0,0,16'h0000, 0,16'h55AA, 0,8'h00,8'h00, 9),  // R9 stack now holds old HL
    v(0,4,0,0,16'h0001, 4,16'h0001, 0,8'h00,8'h00, 10), // R10 SP near zero
    v(1,1,0,0,16'h0000, 4,16'hFFFF, 1,8'hFF,8'h34, 10), // R10 push wraps
    v(2,0,0,0,16'h0000, 0,16'h1234, 1,8'h00,8'h12, 10), // R10 pop wraps back
    v(7,0,0,0,16'h0000, 4,16'h0001, 0,8'h00,8'h00, 10)  // R10 SP after wrap
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] rdreg(input logic [2:0] s);
    case (s)
      3'd0: return bc_q;
      3'd1: return de_q;
      3'd2: return hl_q;
      3'd3: return psw_q;
      3'd4: return sp_q;
      default: return pc_q;
    endcase
  endfunction

  task automatic issue(input logic [2:0] c, input logic [2:0] s, input logic [2:0] cc,
                       input logic ce, input logic [15:0] op,
                       output int lat, output int acc);
    int a0;
    @(negedge clk);
    cmd = c; pair_sel = s; cond_code = cc; cond_en = ce; operand = op;
    start = 1'b1;
    a0 = acc_cnt;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 50) begin
      @(negedge clk);
      lat++;
    end
    acc = acc_cnt - a0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int lat, acc;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 sp", sp_q, 16'h0000);
    check("R1 pc", pc_q, 16'h0000);
    check("R1 hl", hl_q, 16'h0000);
    check("R1 strobes/done/busy", {12'd0, mem_rd, mem_wr, done, busy}, 16'h0000);
    rst = 1'b0;

    for (int i = 0; i < 29; i++) begin
      logic [71:0] e;
      e = VEC[i];
      issue(e[71:69], e[68:66], e[65:63], e[62], e[61:46], lat, acc);
      nchk++;
      if (rdreg(e[45:43]) !== e[42:27]) begin
        nfail++;
        $display("FAIL R%0d vector %0d actual=%h expected=%h",
                 e[9:6], i, rdreg(e[45:43]), e[42:27]);
      end
      if (e[26]) begin
        nchk++;
        if (mem[e[25:18]] !== e[17:10]) begin
          nfail++;
          $display("FAIL R%0d vector %0d mem[%h] actual=%h expected=%h",
                   e[9:6], i, e[25:18], mem[e[25:18]], e[17:10]);
        end
      end
    end
    // state now: BC=1234 DE=1234 HL=1234 PSW=A5C4 SP=0001 PC=2003

    issue(0, 4, 0, 0, 16'h0080, lat, acc);
    check("R2 load latency", 16'(lat), 16'd1);
    check("R2 load no access", 16'(acc), 16'd0);

    issue(1, 2, 0, 0, 16'h0, lat, acc);
    check("R3 push latency", 16'(lat), 16'd4);
    check("R3 push accesses", 16'(acc), 16'd2);

    issue(2, 1, 0, 0, 16'h0, lat, acc);
    check("R4 pop latency", 16'(lat), 16'd5);
    check("R4 pop accesses", 16'(acc), 16'd2);

    issue(6, 0, 0, 0, 16'h0, lat, acc);
    check("R9 xstk latency", 16'(lat), 16'd6);
    check("R9 xstk accesses", 16'(acc), 16'd4);
    check("R9 xstk hl", hl_q, 16'h0000);
    check("R9 xstk mem hi", {8'h00, mem[8'h81]}, 16'h0012);
    check("R9 xstk sp", sp_q, 16'h0080);

    issue(3, 0, 3, 1, 16'h7777, lat, acc);
    check("R7 false latency", 16'(lat), 16'd1);
    check("R7 false no access", 16'(acc), 16'd0);
    check("R7 false pc", pc_q, 16'h2003);
    check("R7 false sp", sp_q, 16'h0080);

    issue(5, 0, 0, 0, 16'h0, lat, acc);
    check("R8 xde latency", 16'(lat), 16'd1);
    check("R8 xde no access", 16'(acc), 16'd0);
    check("R8 xde hl", hl_q, 16'h1234);

    issue(7, 0, 0, 0, 16'h0, lat, acc);
    check("R12 nop latency", 16'(lat), 16'd1);

    // R11: start during busy is ignored
    @(negedge clk);
    cmd = 3'd1; pair_sel = 3'd0; cond_en = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    cmd = 3'd0; pair_sel = 3'd0; operand = 16'hDEAD; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    check("R11 bc untouched", bc_q, 16'h1234);
    check("R11 sp after push", sp_q, 16'h007E);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule